// File: doc/BRIEF.md
# Partial-Scan Test Sequencer

This block runs the clock and shift-control schedule for a circuit whose flip-flops are split into two groups. The scanned flip-flops sit on one serial chain. The unscanned flip-flops are left off the chain. Each group has its own clock enable. In shift mode only the chain is clocked, so the unscanned state holds. In capture mode both groups take one clock together.

A run starts with a `start` pulse. The vector count and the chain length are taken at that moment. The sequencer first pushes a fixed 0,0,1,1,0,0,1,1,... pattern through the chain for four clocks more than the chain length. This confirms that the shift path works. Each vector is then loaded serially from the `stim_bit_i` input and captured in a single cycle. While one vector is being loaded, the state captured by the previous vector shifts out at the far end of the chain. A final unload phase empties the chain after the last capture.

An active-cycle counter is kept on an output. After a run it equals (V + 2) * L + V + 4, where V is the vector count and L is the chain length. A one-cycle completion pulse marks the end of the run.

Top module: `pscan_seq`

## Requirements
- R1: While reset is applied, and until a run starts, both clock enables, the shift select, the serial output and the done flag are 0. The cycle counter is 0 after reset.
- R2: The first L+4 active cycles of a run have the shift select at 1, the chain enable at 1 and the core enable at 0. The serial output follows the repeating pattern 0,0,1,1, starting at the first of these cycles.
- R3: Whenever the shift select is 1, the chain enable is 1 and the core enable is 0.
- R4: Before each capture there are L load cycles. In each one the shift select is 1 and the serial output equals `stim_bit_i` in the same cycle.
- R5: Each vector has exactly one capture cycle. In that cycle the shift select is 0 and both enables are 1.
- R6: The last capture is followed by L unload cycles. In each one the shift select is 1 and the serial output is 0.
- R7: The done flag is 1 for exactly one cycle, in the cycle right after the last active cycle. At that point the cycle counter equals (V+2)*L+V+4, and it keeps that value until the next run starts.
- R8: A `start` pulse during a run changes nothing. The schedule and the cycle count still follow the values taken when the run began.
- R9: A zero vector count gives a flush followed directly by the unload. A zero chain length gives phases of zero length, so a run with V=0 and L=0 lasts exactly 4 active cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a run when the sequencer is idle |
| num_vec_i | input | VEC_W | Number of test vectors (V) |
| scan_len_i | input | LEN_W | Number of scanned flip-flops (L) |
| stim_bit_i | input | 1 | Serial stimulus bit for the vector loads |
| scan_clk_en_o | output | 1 | Clock enable for the scanned flip-flops |
| core_clk_en_o | output | 1 | Clock enable for the unscanned flip-flops |
| tc_o | output | 1 | Shift select (1 = shift, 0 = capture) |
| scan_in_o | output | 1 | Serial bit into the head of the chain |
| done_o | output | 1 | One-cycle run completion pulse |
| cycle_cnt_o | output | VEC_W+LEN_W+2 | Active cycles in the current or last run |

## Verification
The bench builds the sequencer with VEC_W=4 and LEN_W=4. This keeps a run short enough to compare cycle by cycle. It also puts the widest settings within reach: fifteen vectors on a fifteen-bit chain, a 274-cycle run whose flush counter reaches its highest value.

At these widths the runs also cover:
- a zero-length chain, where captures come back to back;
- a zero vector count;
- the four-cycle minimum run;
- a run in which a second `start` pulse arrives carrying different settings.

// File: rtl/pscan_pkg.sv
package pscan_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FLUSH,
    PH_LOAD,
    PH_CAPT,
    PH_UNLOAD,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/pscan_rst_sync.sv
module pscan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pscan_fsm.sv
module pscan_fsm
  import pscan_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VEC_W-1:0] num_vec,
  input  logic [LEN_W-1:0] scan_len,
  output logic             start_ack,
  output logic             active,
  output logic             capture,
  output logic             in_flush,
  output logic             in_load,
  output logic             in_unload,
  output logic             flush_bit,
  output logic             done
);
  localparam int PH_W = LEN_W + 1;

  phase_e           state_q, state_d;
  logic [PH_W-1:0]  cnt_q, cnt_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic [VEC_W-1:0] nvec_q, nvec_d;
  logic [LEN_W-1:0] len_q, len_d;

  logic [PH_W-1:0] flush_last;
  logic [PH_W-1:0] shift_last;
  logic            len_zero;
  logic            last_vec;

  assign flush_last = {1'b0, len_q} + PH_W'(3);
  assign shift_last = {1'b0, len_q} - PH_W'(1);
  assign len_zero   = (len_q == '0);
  assign last_vec   = (vec_q == nvec_q - VEC_W'(1));

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    vec_d     = vec_q;
    nvec_d    = nvec_q;
    len_d     = len_q;
    start_ack = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (start) begin
          start_ack = 1'b1;
          nvec_d    = num_vec;
          len_d     = scan_len;
          cnt_d     = '0;
          vec_d     = '0;
          state_d   = PH_FLUSH;
        end
      end
      PH_FLUSH: begin
        if (cnt_q == flush_last) begin
          cnt_d = '0;
          if (nvec_q == '0) state_d = len_zero ? PH_DONE : PH_UNLOAD;
          else              state_d = len_zero ? PH_CAPT : PH_LOAD;
        end else begin
          cnt_d = cnt_q + PH_W'(1);
        end
      end
      PH_LOAD: begin
        if (cnt_q == shift_last) begin
          cnt_d   = '0;
          state_d = PH_CAPT;
        end else begin
          cnt_d = cnt_q + PH_W'(1);
        end
      end
      PH_CAPT: begin
        vec_d = vec_q + VEC_W'(1);
        if (last_vec) state_d = len_zero ? PH_DONE : PH_UNLOAD;
        else          state_d = len_zero ? PH_CAPT : PH_LOAD;
      end
      PH_UNLOAD: begin
        if (cnt_q == shift_last) begin
          cnt_d   = '0;
          state_d = PH_DONE;
        end else begin
          cnt_d = cnt_q + PH_W'(1);
        end
      end
      PH_DONE: state_d = PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      vec_q   <= '0;
      nvec_q  <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      vec_q   <= vec_d;
      nvec_q  <= nvec_d;
      len_q   <= len_d;
    end
  end

  assign in_flush  = (state_q == PH_FLUSH);
  assign in_load   = (state_q == PH_LOAD);
  assign in_unload = (state_q == PH_UNLOAD);
  assign capture   = (state_q == PH_CAPT);
  assign active    = in_flush | in_load | in_unload | capture;
  assign flush_bit = cnt_q[1];
  assign done      = (state_q == PH_DONE);

  // Settings are frozen once a run is under way
  AST_SETTINGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start) |=> ($stable(nvec_q) && $stable(len_q))); // R8

  // Flush pattern has period four
  AST_FLUSH_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flush && cnt_q >= PH_W'(4)) |-> (flush_bit == $past(flush_bit, 4))); // R2

  // Capture never repeats unless the chain is empty
  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !len_zero) |=> !capture); // R5
endmodule

// File: rtl/pscan_cycle_ctr.sv
module pscan_cycle_ctr #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)    cnt_d = '0;
    else if (inc) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // Count holds outside active cycles
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !inc) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/pscan_seq.sv
module pscan_seq #(
  parameter int VEC_W = 8,
  parameter int LEN_W = 8,
  localparam int CNT_W = VEC_W + LEN_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VEC_W-1:0] num_vec_i,
  input  logic [LEN_W-1:0] scan_len_i,
  input  logic             stim_bit_i,
  output logic             scan_clk_en_o,
  output logic             core_clk_en_o,
  output logic             tc_o,
  output logic             scan_in_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cycle_cnt_o
);
  logic rst_n_int;
  logic start_ack, active, capture, in_flush, in_load, in_unload;
  logic flush_bit, done;

  pscan_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  pscan_fsm #(.VEC_W(VEC_W), .LEN_W(LEN_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start    (start_i),
    .num_vec  (num_vec_i),
    .scan_len (scan_len_i),
    .start_ack(start_ack),
    .active   (active),
    .capture  (capture),
    .in_flush (in_flush),
    .in_load  (in_load),
    .in_unload(in_unload),
    .flush_bit(flush_bit),
    .done     (done)
  );

  pscan_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n_int),
    .clear(start_ack),
    .inc  (active),
    .count(cycle_cnt_o)
  );

  assign scan_clk_en_o = active;
  assign core_clk_en_o = capture;
  assign tc_o          = in_flush | in_load | in_unload;
  assign scan_in_o     = (in_flush & flush_bit) | (in_load & stim_bit_i);
  assign done_o        = done;

  // Shift mode never clocks the unscanned flip-flops
  AST_SHIFT_GATES_CORE: assert property (@(posedge clk) disable iff (!rst_n_int)
    tc_o |-> (scan_clk_en_o && !core_clk_en_o)); // R3

  // Done is a single-cycle pulse
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n_int)
    done_o |=> !done_o); // R7

  // Done follows directly on an active cycle
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(done_o) |-> $past(scan_clk_en_o)); // R7

  // Unload drives zeros into the chain
  AST_UNLOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    in_unload |-> !scan_in_o); // R6
endmodule

// File: tb/pscan_seq_bench.sv
module pscan_seq_bench;
  localparam int VW = 4;
  localparam int LW = 4;
  localparam int CW = VW + LW + 2;

  typedef struct packed {
    logic        sen;
    logic        cen;
    logic        tc;
    logic        sin;
    logic        use_stim;
    logic        done;
    logic [31:0] cnt;
    logic [7:0]  req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [VW-1:0] num_vec_i = '0;
  logic [LW-1:0] scan_len_i = '0;
  logic          stim_bit_i;
  logic          scan_clk_en_o, core_clk_en_o, tc_o, scan_in_o, done_o;
  logic [CW-1:0] cycle_cnt_o;
  logic [7:0]    lfsr = 8'hA5;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   armed   = 1'b0;
  item_t exp_q[$];

  always #2 clk = ~clk;

  always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  assign stim_bit_i = lfsr[0];

  pscan_seq #(.VEC_W(VW), .LEN_W(LW)) u_pscan_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .num_vec_i    (num_vec_i),
    .scan_len_i   (scan_len_i),
    .stim_bit_i   (stim_bit_i),
    .scan_clk_en_o(scan_clk_en_o),
    .core_clk_en_o(core_clk_en_o),
    .tc_o         (tc_o),
    .scan_in_o    (scan_in_o),
    .done_o       (done_o),
    .cycle_cnt_o  (cycle_cnt_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares them to the ports
  always @(negedge clk) begin
    if (armed && exp_q.size() != 0) begin
      item_t it;
      logic  exp_sin;
      string rq;
      it = exp_q.pop_front();
      rq = $sformatf("R%0d", it.req);
      exp_sin = it.use_stim ? stim_bit_i : it.sin;
      check(scan_clk_en_o == it.sen, rq, "scan_clk_en", int'(scan_clk_en_o), int'(it.sen));
      check(core_clk_en_o == it.cen, rq, "core_clk_en", int'(core_clk_en_o), int'(it.cen));
      check(tc_o == it.tc, rq, "tc", int'(tc_o), int'(it.tc));
      check(scan_in_o == exp_sin, rq, "scan_in", int'(scan_in_o), int'(exp_sin));
      check(done_o == it.done, rq, "done", int'(done_o), int'(it.done));
      if (it.done)
        check(int'(cycle_cnt_o) == int'(it.cnt), rq, "cycle_cnt", int'(cycle_cnt_o), int'(it.cnt));
    end
  end

  function automatic item_t mk(bit sen, bit cen, bit tc, bit sin, bit st,
                               bit dn, int cnt, int req);
    item_t it;
    it.sen = sen; it.cen = cen; it.tc = tc; it.sin = sin;
    it.use_stim = st; it.done = dn; it.cnt = 32'(cnt); it.req = 8'(req);
    return it;
  endfunction

  // Driver: pushes the expected schedule, then starts the run
  task automatic run_seq(input int nv, input int sl, input bit poke);
    int total;
    total = (nv + 2) * sl + nv + 4;
    for (int i = 0; i < sl + 4; i++)
      exp_q.push_back(mk(1, 0, 1, (i % 4) >= 2, 0, 0, 0, 2));   // R2 flush
    for (int v = 0; v < nv; v++) begin
      for (int i = 0; i < sl; i++)
        exp_q.push_back(mk(1, 0, 1, 0, 1, 0, 0, 4));            // R4 load
      exp_q.push_back(mk(1, 1, 0, 0, 0, 0, 0, 5));              // R5 capture
    end
    for (int i = 0; i < sl; i++)
      exp_q.push_back(mk(1, 0, 1, 0, 0, 0, 0, 6));              // R6 unload
    exp_q.push_back(mk(0, 0, 0, 0, 0, 1, total, 7));            // R7 done
    @(negedge clk);
    num_vec_i  = VW'(nv);
    scan_len_i = LW'(sl);
    start_i    = 1'b1;
    @(posedge clk);
    #1;
    start_i = 1'b0;
    armed   = 1'b1;
    if (poke) begin
      // R8: a second start with other settings mid-run
      repeat (3) @(negedge clk);
      num_vec_i  = VW'(nv + 3);
      scan_len_i = LW'(sl + 2);
      start_i    = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (exp_q.size() != 0) begin
      @(negedge clk);
      #1;
    end
    armed = 1'b0;
    @(negedge clk);
    #1;
    check(done_o == 1'b0, "R7", "done after pulse", int'(done_o), 0);
    check(int'(cycle_cnt_o) == total, "R7", "cycle_cnt held", int'(cycle_cnt_o), total);
    check(scan_clk_en_o == 1'b0, "R1", "idle scan_clk_en", int'(scan_clk_en_o), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(scan_clk_en_o == 1'b0 && core_clk_en_o == 1'b0 && tc_o == 1'b0,
          "R1", "enables in reset", int'({scan_clk_en_o, core_clk_en_o, tc_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done_o == 1'b0, "R1", "done after reset", int'(done_o), 0);
    check(scan_in_o == 1'b0, "R1", "scan_in after reset", int'(scan_in_o), 0);
    check(int'(cycle_cnt_o) == 0, "R1", "cycle_cnt after reset", int'(cycle_cnt_o), 0);
    run_seq(3, 5, 0);    // R4 R5 typical run
    run_seq(0, 4, 0);    // R9 no vectors
    run_seq(2, 0, 0);    // R9 empty chain, back-to-back captures
    run_seq(0, 0, 0);    // R9 minimum run of four cycles
    run_seq(2, 3, 1);    // R8 start ignored while busy
    run_seq(5, 1, 0);
    run_seq(15, 15, 0);  // widest settings
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule